// File: doc/BRIEF.md
# Stepper coil blanking-integration sequencer

This block drives the two coils of a small two-phase stepper motor while a return-to-zero routine looks for a stall. Configuration inputs choose the full-step field angle, the recirculation path, the sign of integration and whether the driven coil stays powered in each phase. All of these are held as static levels by the register logic around the block. While the block is enabled it owns the eight bridge switches: a high-side and a low-side switch on each of the four bridge legs. While it is disabled, every switch is off.

A one-cycle trigger pulse starts a measurement sequence. The sequence has two phases. In the blanking phase, the coil under measurement (the one the current step does not select) recirculates its current through either both of its high-side switches or both of its low-side switches. In the integration phase, that coil floats, and the block raises an integration enable and a sign for a downstream integrator. Two 16-bit length inputs set how long each phase lasts. Any change to a leg's drive passes through one cycle of dead time, so the two switches of a leg are never on together.

Top module: `stall_seq_top`

## Requirements
- R1: After reset, every switch output, both phase status outputs, `integEn` and `integSign` are 0.
- R2: Outside a sequence, with `enable`=1 and `driveInteg`=1, the selected coil is driven. The legs are indexed 0 = coil A plus, 1 = coil A minus, 2 = coil B plus, 3 = coil B minus. `stepSel` 00 gives hsOn=0001, lsOn=0010. `stepSel` 01 gives hsOn=0100, lsOn=1000. `stepSel` 10 gives hsOn=0010, lsOn=0001. `stepSel` 11 gives hsOn=1000, lsOn=0100. The other coil is off.
- R3: With `driveInteg`=0, no switch is on outside a sequence.
- R4: A `trigger` pulse while enabled and idle makes `blankBusy` 1 from the next cycle. `blankBusy` stays 1 for max(`blankLen`,1) cycles. `integBusy` then stays 1 for max(`integLen`,1) cycles, starting on the cycle after blanking ends. The two status outputs are never 1 together.
- R5: During blanking, the measured coil has both low-side switches on when `recircLow`=1, or both high-side switches on when `recircLow`=0. The switches on its other side are off.
- R6: During blanking, the selected coil is driven per the R2 mapping when `driveBlank`=1, and is off when `driveBlank`=0.
- R7: During integration, all four switches of the measured coil are off, `integEn`=1 and `integSign` equals `integDir`. The selected coil follows `driveInteg` as in R2 and R3. Outside integration, `integEn` and `integSign` are 0.
- R8: A `trigger` pulse during either phase does not change the length or order of the running sequence, and does not start a new one.
- R9: With `enable`=0, from the next cycle every switch is off and both status outputs are 0. A `trigger` pulse while disabled starts nothing. Clearing `enable` mid-sequence aborts the sequence.
- R10: Switch outputs follow the requested drive one cycle later. When a leg's requested drive changes, both of that leg's switches are off for one cycle before the new drive appears. A leg never has its high-side and low-side switches on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block owns the coils when 1 |
| trigger | input | 1 | One-cycle pulse that starts a sequence |
| stepSel | input | 2 | Full-step field angle |
| recircLow | input | 1 | Blanking recirculation path: 1 low side, 0 high side |
| integDir | input | 1 | Integration sign |
| driveBlank | input | 1 | Drive the selected coil during blanking |
| driveInteg | input | 1 | Drive the selected coil during integration and when idle |
| blankLen | input | 16 | Blanking length in cycles (0 treated as 1) |
| integLen | input | 16 | Integration length in cycles (0 treated as 1) |
| hsOn | output | 4 | High-side switch enables per leg |
| lsOn | output | 4 | Low-side switch enables per leg |
| integEn | output | 1 | Integrator enable |
| integSign | output | 1 | Integrator sign |
| blankBusy | output | 1 | Blanking phase in progress |
| integBusy | output | 1 | Integration phase in progress |

## Verification
The hardest situations to reach from the ports are a trigger that lands in the middle of a running phase and an enable that drops partway through blanking. Both need the stimulus to know exactly where the sequence stands. A sequence task therefore counts each phase's cycles through the status outputs, and it can inject a trigger pulse on a chosen cycle of either phase or clear `enable` on a chosen blanking cycle. Settled switch patterns are checked two cycles into each phase, after the dead-time cycle has passed. A per-cycle reference model checks every other cycle, including each dead-time gap.

// File: rtl/stall_seq_pkg.sv
package stall_seq_pkg;

  // Two coils, each an H-bridge with a plus leg and a minus leg.
  localparam int COIL_N = 2;
  localparam int LEG_N  = 2 * COIL_N;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_INTEG = 2'd2
  } phaseT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic inBlank;
    logic inInteg;
  } ctrlStrobeT;

  // Drive request for one bridge leg.
  typedef struct packed {
    logic hi;
    logic lo;
  } legDriveT;

endpackage

// File: rtl/stall_seq_ctrl.sv
module stall_seq_ctrl
  import stall_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             trigger,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] integLen,
  output ctrlStrobeT       strobe
);

  phaseT            phase, phaseNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   cntInc;
  logic             lastCycle;

  // The length of the current phase is read live; a length of 0 acts as 1.
  assign limit     = (phase == PH_BLANK) ? blankLen : integLen;
  assign cntInc    = {1'b0, cnt} + 1'b1;
  assign lastCycle = cntInc >= {1'b0, limit};

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cntInc[CNT_W-1:0];
    if (!enable) begin
      phaseNxt = PH_IDLE;
      cntNxt   = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cntNxt = '0;
          if (trigger) phaseNxt = PH_BLANK;
        end
        PH_BLANK: begin
          if (lastCycle) begin
            phaseNxt = PH_INTEG;
            cntNxt   = '0;
          end
        end
        PH_INTEG: begin
          if (lastCycle) begin
            phaseNxt = PH_IDLE;
            cntNxt   = '0;
          end
        end
        default: begin
          phaseNxt = PH_IDLE;
          cntNxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

  assign strobe.inBlank = (phase == PH_BLANK);
  assign strobe.inInteg = (phase == PH_INTEG);

endmodule

// File: rtl/stall_seq_datapath.sv
module stall_seq_datapath
  import stall_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  ctrlStrobeT       strobe,
  input  logic [1:0]       stepSel,
  input  logic             recircLow,
  input  logic             integDir,
  input  logic             driveBlank,
  input  logic             driveInteg,
  output logic [LEG_N-1:0] hsOn,
  output logic [LEG_N-1:0] lsOn,
  output logic             integEn,
  output logic             integSign
);

  logic             selCoil, selNeg, measCoil, driveSel;
  logic [LEG_N-1:0] reqHi, reqLo;

  // stepSel[0] picks the coil (0 = A, 1 = B); stepSel[1] picks the polarity.
  assign selCoil  = stepSel[0];
  assign selNeg   = stepSel[1];
  assign measCoil = ~selCoil;
  assign driveSel = strobe.inBlank ? driveBlank : driveInteg;

  // Leg index = {coil, side}, where side 0 = plus leg and 1 = minus leg.
  always_comb begin
    reqHi = '0;
    reqLo = '0;
    if (enable) begin
      if (driveSel) begin
        reqHi[{selCoil, selNeg}]  = 1'b1;
        reqLo[{selCoil, ~selNeg}] = 1'b1;
      end
      if (strobe.inBlank) begin
        if (recircLow) begin
          reqLo[{measCoil, 1'b0}] = 1'b1;
          reqLo[{measCoil, 1'b1}] = 1'b1;
        end else begin
          reqHi[{measCoil, 1'b0}] = 1'b1;
          reqHi[{measCoil, 1'b1}] = 1'b1;
        end
      end
    end
  end

  // Per-leg output register: a change in the requested drive costs one
  // cycle with both switches off.
  for (genvar g = 0; g < LEG_N; g++) begin : gLeg
    legDriveT curReq, prevReq;
    logic     hiQ, loQ;

    assign curReq = {reqHi[g], reqLo[g]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevReq <= '0;
        hiQ     <= 1'b0;
        loQ     <= 1'b0;
      end else begin
        prevReq <= curReq;
        if (curReq != prevReq) begin
          hiQ <= 1'b0;
          loQ <= 1'b0;
        end else begin
          hiQ <= curReq.hi;
          loQ <= curReq.lo;
        end
      end
    end

    assign hsOn[g] = hiQ;
    assign lsOn[g] = loQ;
  end

  assign integEn   = strobe.inInteg;
  assign integSign = strobe.inInteg & integDir;

endmodule

// File: rtl/stall_seq_top.sv
module stall_seq_top
  import stall_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             trigger,
  input  logic [1:0]       stepSel,
  input  logic             recircLow,
  input  logic             integDir,
  input  logic             driveBlank,
  input  logic             driveInteg,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] integLen,
  output logic [3:0]       hsOn,
  output logic [3:0]       lsOn,
  output logic             integEn,
  output logic             integSign,
  output logic             blankBusy,
  output logic             integBusy
);

  ctrlStrobeT strobe;

  stall_seq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .trigger  (trigger),
    .blankLen (blankLen),
    .integLen (integLen),
    .strobe   (strobe)
  );

  stall_seq_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .strobe     (strobe),
    .stepSel    (stepSel),
    .recircLow  (recircLow),
    .integDir   (integDir),
    .driveBlank (driveBlank),
    .driveInteg (driveInteg),
    .hsOn       (hsOn),
    .lsOn       (lsOn),
    .integEn    (integEn),
    .integSign  (integSign)
  );

  assign blankBusy = strobe.inBlank;
  assign integBusy = strobe.inInteg;

endmodule

// File: rtl/stall_seq_chk.sv
module stall_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       trigger,
  input logic       integDir,
  input logic [3:0] hsOn,
  input logic [3:0] lsOn,
  input logic       integEn,
  input logic       integSign,
  input logic       blankBusy,
  input logic       integBusy
);

  assert_leg_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hsOn & lsOn) == 4'b0);

  assert_dead_time_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((hsOn & $past(lsOn)) | (lsOn & $past(hsOn))) == 4'b0);

  assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hsOn == 4'b0 && lsOn == 4'b0 && !blankBusy && !integBusy));

  assert_trigger_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && trigger && !blankBusy && !integBusy) |=> blankBusy);

  assert_phase_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(blankBusy && integBusy));

  assert_phase_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(integBusy) |-> $past(blankBusy));

  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rstN)
    integBusy |=> !blankBusy);

  assert_integ_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    integBusy |-> (integEn && integSign == integDir));

  assert_integ_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !integBusy |-> (!integEn && !integSign));

endmodule

bind stall_seq_top stall_seq_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .trigger   (trigger),
  .integDir  (integDir),
  .hsOn      (hsOn),
  .lsOn      (lsOn),
  .integEn   (integEn),
  .integSign (integSign),
  .blankBusy (blankBusy),
  .integBusy (integBusy)
);

// File: tb/stall_seq_tb.sv
`timescale 1ns/1ps
module stall_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        trigger = 1'b0;
  logic [1:0]  stepSel = 2'd0;
  logic        recircLow = 1'b0;
  logic        integDir = 1'b0;
  logic        driveBlank = 1'b0;
  logic        driveInteg = 1'b0;
  logic [15:0] blankLen = 16'd5;
  logic [15:0] integLen = 16'd5;
  logic [3:0]  hsOn, lsOn;
  logic        integEn, integSign, blankBusy, integBusy;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  stall_seq_top dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .trigger(trigger),
    .stepSel(stepSel), .recircLow(recircLow), .integDir(integDir),
    .driveBlank(driveBlank), .driveInteg(driveInteg),
    .blankLen(blankLen), .integLen(integLen),
    .hsOn(hsOn), .lsOn(lsOn), .integEn(integEn), .integSign(integSign),
    .blankBusy(blankBusy), .integBusy(integBusy)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // Drive point: 1 ns after a rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // ---------------- behavioural reference model ----------------
  int         mPhase = 0;   // 0 idle, 1 blanking, 2 integration
  int         mLeft  = 0;
  logic [7:0] mPrev  = '0;  // {hi[3:0], lo[3:0]}
  logic [3:0] mHi    = '0;
  logic [3:0] mLo    = '0;

  function automatic logic [7:0] reqFn(int ph, logic en, logic [1:0] st,
                                       logic rl, logic dB, logic dI);
    logic [3:0] hi = '0;
    logic [3:0] lo = '0;
    int s = st[0] ? 1 : 0;
    int n = st[1] ? 1 : 0;
    int m = 1 - s;
    logic drv = (ph == 1) ? dB : dI;
    if (!en) return 8'h00;
    if (drv) begin
      hi[2*s + n]     = 1'b1;
      lo[2*s + 1 - n] = 1'b1;
    end
    if (ph == 1) begin
      if (rl) begin lo[2*m] = 1'b1; lo[2*m+1] = 1'b1; end
      else    begin hi[2*m] = 1'b1; hi[2*m+1] = 1'b1; end
    end
    return {hi, lo};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mPrev = '0; mHi = '0; mLo = '0;
    end else begin
      logic [7:0] rq;
      rq = reqFn(mPhase, enable, stepSel, recircLow, driveBlank, driveInteg);
      for (int l = 0; l < 4; l++) begin
        if ({rq[4+l], rq[l]} != {mPrev[4+l], mPrev[l]}) begin
          mHi[l] = 1'b0; mLo[l] = 1'b0;
        end else begin
          mHi[l] = rq[4+l]; mLo[l] = rq[l];
        end
      end
      mPrev = rq;
      if (!enable) mPhase = 0;
      else if (mPhase == 0) begin
        if (trigger) begin mPhase = 1; mLeft = (blankLen == 0) ? 1 : int'(blankLen); end
      end else if (mPhase == 1) begin
        mLeft--;
        if (mLeft == 0) begin mPhase = 2; mLeft = (integLen == 0) ? 1 : int'(integLen); end
      end else begin
        mLeft--;
        if (mLeft == 0) mPhase = 0;
      end
    end
  end

  // Per-cycle comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk((mPhase == 1) ? "R5 switches" : (mPhase == 2) ? "R7 switches" : "R2 switches",
          {24'd0, hsOn, lsOn}, {24'd0, mHi, mLo});
      chk("R4 status", {30'd0, blankBusy, integBusy}, {30'd0, mPhase == 1, mPhase == 2});
      chk("R7 integrator", {30'd0, integEn, integSign},
          {30'd0, mPhase == 2, (mPhase == 2) && integDir});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finishTest();
    end
  end

  // Run one sequence, count the cycles of each phase and check settled patterns.
  task automatic runSeq(input logic rl, input logic dB, input logic dir,
                        input logic [1:0] st, input bit inject,
                        input int expB, input int expI);
    int nb = 0;
    int ni = 0;
    int s  = st[0] ? 1 : 0;
    int n  = st[1] ? 1 : 0;
    int m  = 1 - s;
    recircLow = rl; driveBlank = dB; integDir = dir; stepSel = st;
    repeat (3) tick();
    trigger = 1'b1;
    tick();
    trigger = 1'b0;
    while (blankBusy && nb < 1000) begin
      nb++;
      if (nb == 3) begin
        chk("R5 measured coil high", (hsOn >> (2*m)) & 4'h3, rl ? 0 : 3);
        chk("R5 measured coil low",  (lsOn >> (2*m)) & 4'h3, rl ? 3 : 0);
        chk("R6 selected coil high", (hsOn >> (2*s)) & 4'h3, dB ? (n ? 2 : 1) : 0);
        chk("R6 selected coil low",  (lsOn >> (2*s)) & 4'h3, dB ? (n ? 1 : 2) : 0);
      end
      trigger = (inject && nb == 2);
      tick();
    end
    trigger = 1'b0;
    while (integBusy && ni < 1000) begin
      ni++;
      if (ni == 3) begin
        chk("R7 measured coil off", ((hsOn | lsOn) >> (2*m)) & 4'h3, 0);
        chk("R7 integrator on", {integEn, integSign}, {1'b1, dir});
      end
      trigger = (inject && ni == 2);
      tick();
    end
    trigger = 1'b0;
    chk(inject ? "R8 blank length with retrigger" : "R4 blank length", nb, expB);
    chk(inject ? "R8 integ length with retrigger" : "R4 integ length", ni, expI);
    repeat (2) tick();
    chk(inject ? "R8 no restart" : "R4 back to idle", {blankBusy, integBusy}, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 reset outputs", {hsOn, lsOn, integEn, integSign, blankBusy, integBusy}, 0);
    rstN = 1'b1;
    tick();
    chk("R1 after release", {hsOn, lsOn, integEn, integSign, blankBusy, integBusy}, 0);

    // R2: step mapping outside a sequence.
    enable = 1'b1; driveInteg = 1'b1;
    for (int st = 0; st < 4; st++) begin
      stepSel = st[1:0];
      repeat (3) tick();
      case (st)
        0: chk("R2 step 00", {hsOn, lsOn}, 8'h12);
        1: chk("R2 step 01", {hsOn, lsOn}, 8'h48);
        2: chk("R2 step 10", {hsOn, lsOn}, 8'h21);
        default: chk("R2 step 11", {hsOn, lsOn}, 8'h84);
      endcase
    end

    // R10: reverse coil A, leg 0 goes high -> off -> low.
    stepSel = 2'd0;
    repeat (3) tick();
    stepSel = 2'd2;
    tick();
    chk("R10 dead cycle leg0", {hsOn[0], lsOn[0]}, 2'b00);
    tick();
    chk("R10 new drive leg0", {hsOn[0], lsOn[0]}, 2'b01);

    // R3: no drive when idle and driveInteg is 0.
    driveInteg = 1'b0;
    repeat (3) tick();
    chk("R3 idle undriven", {hsOn, lsOn}, 0);

    // R4..R8: sequences.
    blankLen = 16'd5; integLen = 16'd5;
    runSeq(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 5, 5);
    driveInteg = 1'b1;
    runSeq(1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 5, 5);
    blankLen = 16'd7; integLen = 16'd4;
    runSeq(1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 7, 4);
    runSeq(1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 7, 4);
    blankLen = 16'd0; integLen = 16'd0;
    runSeq(1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1, 1);
    blankLen = 16'd1; integLen = 16'd2;
    runSeq(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1, 2);

    // R9: abort mid-blanking, then trigger while disabled.
    blankLen = 16'd20; integLen = 16'd5;
    trigger = 1'b1; tick(); trigger = 1'b0;
    repeat (4) tick();
    chk("R9 blanking before abort", blankBusy, 1);
    enable = 1'b0;
    tick();
    chk("R9 abort outputs off", {hsOn, lsOn, blankBusy, integBusy}, 0);
    trigger = 1'b1; tick(); trigger = 1'b0;
    repeat (2) tick();
    chk("R9 trigger ignored when disabled", {hsOn, lsOn, blankBusy, integBusy}, 0);
    enable = 1'b1;
    repeat (4) tick();
    chk("R9 idle drive restored", {hsOn, lsOn}, 8'h12);

    finishTest();
  end

endmodule